// File: doc/BRIEF.md
# Ethernet Frame Receiver with Station Address Filter

This block takes a serial receive stream, one bit per clock with a qualifying valid level, and turns it into the bytes of an Ethernet frame. It removes the preamble and the start delimiter, counts the frame bytes, and compares the destination address with a programmed station address. It writes the bytes of accepted frames to a receive FIFO and checks the frame check sequence once the frame has ended. Every frame that is accepted or cut short produces a single status pulse. That pulse carries good, CRC-error, too-long, runt and dropped flags and the byte count.

Bits arrive least significant bit first. A frame runs from the first destination byte through the last FCS byte. Frames addressed to the station, broadcast frames, and any frame at all in promiscuous mode are accepted. The six destination bytes are held until the address decision is made. When the frame is accepted they are replayed into the FIFO in the idle cycles that come before the next byte, so a rejected frame never writes to the FIFO. A cut or malformed frame drives a discard pulse so the FIFO can remove any partial frame.

Top module: `eth_rx_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, fifo_wr, fifo_discard and stat_valid are low.
- R2: Serial bits are assembled least significant bit first. Preamble bytes 0x55 and the delimiter byte 0xD5 are removed, so the first byte written to the FIFO is the first destination address byte.
- R3: When the destination matches station_addr (first byte on the wire in bits 47:40), every byte from the destination address through the FCS is written to the FIFO in order. One status pulse follows with stat_len equal to the byte count.
- R4: A frame whose destination is neither the station, nor broadcast, nor allowed by promiscuous mode writes no byte and raises no status or discard pulse.
- R5: A frame with destination FF:FF:FF:FF:FF:FF is accepted like a matching frame.
- R6: When promisc is high, a frame with any destination is accepted.
- R7: CRC-32 (reflected, initial all ones) is run over every byte including the FCS. stat_crc_err is set unless the register ends at 0xDEBB20E3, which is the bit reversal of 0xC704DD7B.
- R8: A frame longer than 1518 bytes sets stat_too_long, and only its first 1518 bytes are written. A frame of exactly 1518 bytes is not flagged.
- R9: A frame shorter than 64 bytes sets stat_runt.
- R10: If valid falls during the preamble, in the middle of a byte, or before all six destination bytes have arrived, a status pulse with stat_drop set is issued in the same cycle as a fifo_discard pulse.
- R11: A byte other than 0x55 or 0xD5 in the preamble causes a drop status. The rest of the stream is then ignored until valid goes low.
- R12: stat_good is high exactly when none of the four fault flags is set. A FIFO write and a status pulse never fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data, LSB first |
| rx_dv | input | 1 | Receive data valid |
| station_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| promisc | input | 1 | Accept every destination |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | 8 | FIFO write data |
| fifo_discard | output | 1 | Discard the partial frame written so far |
| stat_valid | output | 1 | End-of-frame status pulse |
| stat_good | output | 1 | Frame passed all checks |
| stat_crc_err | output | 1 | CRC residue mismatch |
| stat_too_long | output | 1 | Frame exceeded the maximum length |
| stat_runt | output | 1 | Frame below the minimum length |
| stat_drop | output | 1 | Frame cut or malformed |
| stat_len | output | 16 | Bytes counted after the delimiter |

## Verification
The stream is driven with four destination kinds: the station, another unicast address, broadcast, and another unicast address with promiscuous mode set. Comparing these separates the match, reject and override paths of the filter. Lengths of 60, 64, 1518 and 1522 bytes sit on both sides of each length limit. A single corrupted payload byte separates the CRC fault from the length faults. Cuts of valid in the preamble, inside the address, and in the middle of a payload byte, plus a wrong delimiter, each lead to a drop by a different route, and the count of bytes written shows whether the replay or the pass-through path ran.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          ADDR_BYTES  = 6;
    localparam logic [7:0]  PRE_BYTE    = 8'h55;
    localparam logic [7:0]  SFD_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_SKIP,
        ST_DROP
    } rx_state_e;

    typedef struct packed {
        logic good;
        logic crc_err;
        logic too_long;
        logic runt;
        logic drop;
    } rx_status_t;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                               input logic [7:0]  b);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            c = (c[0] ^ b[i]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_rx_deser.sv
module eth_rx_deser
    import eth_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              rx_dv,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic              dv_q,
    output logic              eof_stb,
    output logic              eof_partial
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg       <= '0;
            bitcnt      <= '0;
            byte_stb    <= 1'b0;
            byte_data   <= '0;
            dv_q        <= 1'b0;
            eof_stb     <= 1'b0;
            eof_partial <= 1'b0;
        end else begin
            dv_q        <= rx_dv;
            eof_stb     <= dv_q & ~rx_dv;
            eof_partial <= (bitcnt != '0);
            byte_stb    <= 1'b0;
            if (rx_dv) begin
                shreg  <= {rx_bit, shreg[BYTE_W-1:1]};
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                    byte_stb  <= 1'b1;
                    byte_data <= {rx_bit, shreg[BYTE_W-1:1]};
                end
            end else begin
                bitcnt <= '0;
            end
        end
    end

endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
    import eth_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic              residue_ok
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_byte(crc_q, din);
        end
    end

    assign residue_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import eth_rx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         stb,
    input  logic [2:0]                   idx,
    input  logic [BYTE_W-1:0]            din,
    input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
    input  logic                         promisc,
    output logic                         last_byte,
    output logic                         accept
);

    logic              uni_run;
    logic              bc_run;
    logic [BYTE_W-1:0] want;
    logic              uni_hit;
    logic              bc_hit;

    always_comb begin
        want = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (idx == 3'(i)) begin
                want = station_addr[(ADDR_BYTES-1-i)*BYTE_W +: BYTE_W];
            end
        end
    end

    assign uni_hit   = (din == want);
    assign bc_hit    = (din == '1);
    assign last_byte = stb && (idx == 3'(ADDR_BYTES - 1));
    assign accept    = promisc || (uni_run && uni_hit) || (bc_run && bc_hit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            uni_run <= 1'b1;
            bc_run  <= 1'b1;
        end else if (stb) begin
            uni_run <= uni_run & uni_hit;
            bc_run  <= bc_run & bc_hit;
        end
    end

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
    import eth_rx_pkg::*;
#(
    parameter int MAX_LEN = 1518,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rx_bit,
    input  logic                         rx_dv,
    input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
    input  logic                         promisc,
    output logic                         fifo_wr,
    output logic [BYTE_W-1:0]            fifo_data,
    output logic                         fifo_discard,
    output logic                         stat_valid,
    output logic                         stat_good,
    output logic                         stat_crc_err,
    output logic                         stat_too_long,
    output logic                         stat_runt,
    output logic                         stat_drop,
    output logic [LEN_W-1:0]             stat_len
);

    localparam int REP_W = $clog2(ADDR_BYTES + 1);

    logic              byte_stb;
    logic [BYTE_W-1:0] byte_data;
    logic              dv_q;
    logic              eof_stb;
    logic              eof_partial;

    rx_state_e         state;
    logic [LEN_W-1:0]  cnt;
    logic              accepted;
    logic              eof_seen;
    logic              eof_part;
    logic [REP_W-1:0]  rep_cnt;
    logic [BYTE_W-1:0] da_buf [ADDR_BYTES];
    rx_status_t        st;

    logic              start_frame;
    logic              data_stb;
    logic              addr_stb;
    logic              residue_ok;
    logic              last_addr;
    logic              addr_ok;

    assign start_frame = (state == ST_PRE) && byte_stb && (byte_data == SFD_BYTE);
    assign data_stb    = (state == ST_DATA) && byte_stb;
    assign addr_stb    = data_stb && (cnt < LEN_W'(ADDR_BYTES));

    eth_rx_deser u_deser (
        .clk         (clk),
        .rst         (rst),
        .rx_bit      (rx_bit),
        .rx_dv       (rx_dv),
        .byte_stb    (byte_stb),
        .byte_data   (byte_data),
        .dv_q        (dv_q),
        .eof_stb     (eof_stb),
        .eof_partial (eof_partial)
    );

    eth_rx_crc u_crc (
        .clk        (clk),
        .rst        (rst),
        .clr        (start_frame),
        .en         (data_stb),
        .din        (byte_data),
        .residue_ok (residue_ok)
    );

    eth_rx_addr_filter u_addr (
        .clk          (clk),
        .rst          (rst),
        .clr          (start_frame),
        .stb          (addr_stb),
        .idx          (cnt[2:0]),
        .din          (byte_data),
        .station_addr (station_addr),
        .promisc      (promisc),
        .last_byte    (last_addr),
        .accept       (addr_ok)
    );

    always_comb begin
        st          = '0;
        st.drop     = eof_part || !accepted;
        st.crc_err  = !st.drop && !residue_ok;
        st.too_long = !st.drop && (cnt > LEN_W'(MAX_LEN));
        st.runt     = !st.drop && (cnt < LEN_W'(MIN_LEN));
        st.good     = !(st.drop || st.crc_err || st.too_long || st.runt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cnt           <= '0;
            accepted      <= 1'b0;
            eof_seen      <= 1'b0;
            eof_part      <= 1'b0;
            rep_cnt       <= '0;
            fifo_wr       <= 1'b0;
            fifo_data     <= '0;
            fifo_discard  <= 1'b0;
            stat_valid    <= 1'b0;
            stat_good     <= 1'b0;
            stat_crc_err  <= 1'b0;
            stat_too_long <= 1'b0;
            stat_runt     <= 1'b0;
            stat_drop     <= 1'b0;
            stat_len      <= '0;
            for (int i = 0; i < ADDR_BYTES; i++) da_buf[i] <= '0;
        end else begin
            fifo_wr      <= 1'b0;
            fifo_discard <= 1'b0;
            stat_valid   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (dv_q) state <= ST_PRE;
                end
                ST_PRE: begin
                    if (eof_stb) begin
                        stat_valid    <= 1'b1;
                        stat_drop     <= 1'b1;
                        stat_good     <= 1'b0;
                        stat_crc_err  <= 1'b0;
                        stat_too_long <= 1'b0;
                        stat_runt     <= 1'b0;
                        stat_len      <= '0;
                        fifo_discard  <= 1'b1;
                        state         <= ST_IDLE;
                    end else if (byte_stb) begin
                        if (byte_data == SFD_BYTE) begin
                            state    <= ST_DATA;
                            cnt      <= '0;
                            accepted <= 1'b0;
                            eof_seen <= 1'b0;
                            eof_part <= 1'b0;
                            rep_cnt  <= '0;
                        end else if (byte_data != PRE_BYTE) begin
                            stat_valid    <= 1'b1;
                            stat_drop     <= 1'b1;
                            stat_good     <= 1'b0;
                            stat_crc_err  <= 1'b0;
                            stat_too_long <= 1'b0;
                            stat_runt     <= 1'b0;
                            stat_len      <= '0;
                            fifo_discard  <= 1'b1;
                            state         <= ST_DROP;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_stb) begin
                        if (cnt != '1) cnt <= cnt + 1'b1;
                        if (cnt < LEN_W'(ADDR_BYTES)) da_buf[cnt[2:0]] <= byte_data;
                        if (last_addr) begin
                            if (addr_ok) begin
                                accepted <= 1'b1;
                                rep_cnt  <= REP_W'(1);
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        if (accepted && (cnt >= LEN_W'(ADDR_BYTES)) && (cnt < LEN_W'(MAX_LEN))) begin
                            fifo_wr   <= 1'b1;
                            fifo_data <= byte_data;
                        end
                    end
                    if (rep_cnt != '0) begin
                        fifo_wr   <= 1'b1;
                        fifo_data <= da_buf[3'(rep_cnt - 1'b1)];
                        rep_cnt   <= (rep_cnt == REP_W'(ADDR_BYTES)) ? '0 : rep_cnt + 1'b1;
                    end
                    if (eof_stb) begin
                        eof_seen <= 1'b1;
                        eof_part <= eof_partial;
                    end
                    if (eof_seen && (rep_cnt == '0)) begin
                        stat_valid    <= 1'b1;
                        stat_good     <= st.good;
                        stat_crc_err  <= st.crc_err;
                        stat_too_long <= st.too_long;
                        stat_runt     <= st.runt;
                        stat_drop     <= st.drop;
                        stat_len      <= cnt;
                        fifo_discard  <= st.drop;
                        state         <= ST_IDLE;
                    end
                end
                ST_SKIP: begin
                    if (eof_stb) state <= ST_IDLE;
                end
                ST_DROP: begin
                    if (!dv_q) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
    parameter int MAX_LEN = 1518,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_wr,
    input logic             fifo_discard,
    input logic             stat_valid,
    input logic             stat_good,
    input logic             stat_crc_err,
    input logic             stat_too_long,
    input logic             stat_runt,
    input logic             stat_drop,
    input logic [LEN_W-1:0] stat_len
);

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!fifo_wr && !fifo_discard && !stat_valid));

    // R12
    a_r12_good_flags: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_good == !(stat_crc_err || stat_too_long || stat_runt || stat_drop)));

    a_r12_wr_stat_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_wr, stat_valid}));

    // R10
    a_r10_discard_with_drop: assert property (@(posedge clk) disable iff (rst)
        fifo_discard |-> (stat_valid && stat_drop));

    a_r10_drop_discards: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_drop) |-> fifo_discard);

    // R8
    a_r8_long_matches_len: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && !stat_drop) |-> (stat_too_long == (stat_len > LEN_W'(MAX_LEN))));

    // R9
    a_r9_runt_matches_len: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && !stat_drop) |-> (stat_runt == (stat_len < LEN_W'(MIN_LEN))));

endmodule

bind eth_rx_filter eth_rx_filter_chk #(
    .MAX_LEN (MAX_LEN),
    .MIN_LEN (MIN_LEN),
    .LEN_W   (LEN_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fifo_wr       (fifo_wr),
    .fifo_discard  (fifo_discard),
    .stat_valid    (stat_valid),
    .stat_good     (stat_good),
    .stat_crc_err  (stat_crc_err),
    .stat_too_long (stat_too_long),
    .stat_runt     (stat_runt),
    .stat_drop     (stat_drop),
    .stat_len      (stat_len)
);

// File: tb/eth_rx_filter_bench.sv
module eth_rx_filter_bench;

    localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_bit = 1'b0;
    logic        rx_dv = 1'b0;
    logic        promisc = 1'b0;
    logic        fifo_wr, fifo_discard, stat_valid;
    logic [7:0]  fifo_data;
    logic        stat_good, stat_crc_err, stat_too_long, stat_runt, stat_drop;
    logic [15:0] stat_len;

    int checks = 0;
    int errors = 0;
    int wr_n = 0, st_n = 0, disc_n = 0;
    logic [7:0] cap [2048];
    logic [7:0] fb  [2048];
    logic [7:0] strm [2100];
    logic [4:0] last_flags;
    logic [15:0] last_len;

    always #4 clk = ~clk;

    eth_rx_filter u_eth_rx_filter (
        .clk (clk), .rst (rst), .rx_bit (rx_bit), .rx_dv (rx_dv),
        .station_addr (STA), .promisc (promisc),
        .fifo_wr (fifo_wr), .fifo_data (fifo_data), .fifo_discard (fifo_discard),
        .stat_valid (stat_valid), .stat_good (stat_good), .stat_crc_err (stat_crc_err),
        .stat_too_long (stat_too_long), .stat_runt (stat_runt), .stat_drop (stat_drop),
        .stat_len (stat_len)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_wr) begin
                if (wr_n < 2048) cap[wr_n] = fifo_data;
                wr_n++;
            end
            if (stat_valid) begin
                st_n++;
                last_flags = {stat_good, stat_crc_err, stat_too_long, stat_runt, stat_drop};
                last_len = stat_len;
            end
            if (fifo_discard) disc_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c = c_in;
        for (int i = 0; i < 8; i++) c = (c[0] ^ b[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    // kind: 0 station, 1 other unicast, 2 broadcast
    task automatic build(input int kind, input int n);
        logic [31:0] c = '1;
        for (int i = 0; i < 6; i++) begin
            case (kind)
                0: fb[i] = STA[47-8*i -: 8];
                1: fb[i] = 8'h10 + 8'(i);
                default: fb[i] = 8'hFF;
            endcase
        end
        for (int i = 6; i < n - 4; i++) fb[i] = 8'((i * 7 + 3) & 255);
        for (int i = 0; i < n - 4; i++) c = crc_step(c, fb[i]);
        c = ~c;
        for (int i = 0; i < 4; i++) fb[n-4+i] = c[8*i +: 8];
    endtask

    // sends 7 preamble bytes, delimiter sfd, n frame bytes; cut < 0 sends everything
    task automatic send(input logic [7:0] sfd, input int n, input int cut);
        int total;
        int nb;
        for (int i = 0; i < 7; i++) strm[i] = 8'h55;
        strm[7] = sfd;
        for (int i = 0; i < n; i++) strm[8+i] = fb[i];
        total = (8 + n) * 8;
        nb = (cut >= 0 && cut < total) ? cut : total;
        wr_n = 0; st_n = 0; disc_n = 0; last_flags = '0; last_len = '0;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            rx_dv  = 1'b1;
            rx_bit = strm[b/8][b%8];
        end
        @(negedge clk);
        rx_dv = 1'b0;
        rx_bit = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic check_accept(input string req, input int n, input logic [4:0] flags);
        int cap_n = (n > 1518) ? 1518 : n;
        bit same = 1'b1;
        chk(wr_n == cap_n, req, wr_n, cap_n);
        for (int i = 0; i < cap_n && i < 2048; i++) if (cap[i] !== fb[i]) same = 1'b0;
        chk(same, req, 0, 1);
        chk(st_n == 1, req, st_n, 1);
        chk(last_flags == flags, req, last_flags, flags);
        chk(last_len == 16'(n), req, last_len, n);
        chk(disc_n == 0, req, disc_n, 0);
    endtask

    task automatic check_drop(input string req, input int exp_wr);
        chk(wr_n == exp_wr, req, wr_n, exp_wr);
        chk(st_n == 1, req, st_n, 1);
        chk(last_flags == 5'b00001, req, last_flags, 5'b00001);
        chk(disc_n == 1, req, disc_n, 1);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!fifo_wr && !fifo_discard && !stat_valid, "R1 during reset", {fifo_wr, fifo_discard, stat_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!fifo_wr && !fifo_discard && !stat_valid, "R1 after reset", {fifo_wr, fifo_discard, stat_valid}, 0);

        // R2 R3: station match, minimum length, good
        build(0, 64); send(8'hD5, 64, -1);
        check_accept("R2 R3 unicast 64", 64, 5'b10000);
        // R3: a longer good frame
        build(0, 300); send(8'hD5, 300, -1);
        check_accept("R3 unicast 300", 300, 5'b10000);
        // R4: other unicast rejected
        build(1, 100); send(8'hD5, 100, -1);
        chk(wr_n == 0, "R4 no writes", wr_n, 0);
        chk(st_n == 0 && disc_n == 0, "R4 no status", st_n + disc_n, 0);
        // R5: broadcast
        build(2, 80); send(8'hD5, 80, -1);
        check_accept("R5 broadcast", 80, 5'b10000);
        // R6: promiscuous
        promisc = 1'b1;
        build(1, 70); send(8'hD5, 70, -1);
        check_accept("R6 promisc", 70, 5'b10000);
        promisc = 1'b0;
        // R7: corrupted payload byte
        build(0, 90); fb[40] = fb[40] ^ 8'h04; send(8'hD5, 90, -1);
        check_accept("R7 crc error", 90, 5'b01000);
        // R9: runt
        build(0, 60); send(8'hD5, 60, -1);
        check_accept("R9 runt", 60, 5'b00010);
        // R8: exactly max and over max
        build(0, 1518); send(8'hD5, 1518, -1);
        check_accept("R8 max length", 1518, 5'b10000);
        build(0, 1522); send(8'hD5, 1522, -1);
        check_accept("R8 too long", 1522, 5'b00100);
        // R10: cut inside a payload byte
        build(0, 100); send(8'hD5, 100, 64 + 8*20 + 3);
        check_drop("R10 mid byte", 20);
        // R10: cut inside the destination address
        build(0, 100); send(8'hD5, 100, 64 + 8*4);
        check_drop("R10 in address", 0);
        // R10: cut during preamble
        build(0, 100); send(8'hD5, 100, 8*3 + 4);
        check_drop("R10 in preamble", 0);
        // R11: bad delimiter byte
        build(0, 100); send(8'h5D, 100, -1);
        check_drop("R11 bad delimiter", 0);
        // R12: normal frame after faults
        build(0, 128); send(8'hD5, 128, -1);
        check_accept("R12 recovery", 128, 5'b10000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule